// File: doc/BRIEF.md
# Execute-Stage Arithmetic/Logic Unit

This block is the arithmetic and logic unit in the execute stage of a 32-bit RISC core. Each cycle it can accept one data-processing operation. The operation is given as a 4-bit opcode, a first operand taken from a register, and a second operand that an upstream shifter has already prepared. With these come the shifter's carry-out and the current carry and overflow flags. One clock later the unit returns a 32-bit result, a write enable for that result, and new N, Z, C and V flags.

A small front end either swaps the two operands or complements the operand that reaches the second input. This lets all sixteen operations share one logic unit and one adder. Arithmetic runs in the upper half of an adder that is twice the data width. The lower half of that adder is kept at zero, except for one injection bit that supplies the carry-in. Compare and test operations still compute their value and drive it on the result port, but they hold the write enable low, so only the flags take effect.

Top module: `exu_alu`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), out_valid and res_we are 0 at the following edge, whatever in_valid carries.
- R2: out_valid equals in_valid from the previous clock edge. The result and flags of an operation accepted at one edge appear after the next edge.
- R3: Opcodes 0, 1, 8, 9, 12, 13, 14 and 15 are logic operations. They give a AND b (0 and 8), a XOR b (1 and 9), a OR b (12), b (13), a AND NOT b (14) and NOT b (15).
- R4: Opcodes 4 (add), 11 (compare-negative) and 5 (add with carry) give a + b, with c_in added for opcode 5. C is the carry out of bit 31.
- R5: Opcodes 2 (subtract), 10 (compare) and 6 (subtract with carry) give a - b, or a - b - 1 + c_in for opcode 6. C is 1 when no borrow occurs.
- R6: Opcodes 3 (reverse subtract) and 7 (reverse subtract with carry) give b - a, or b - a - 1 + c_in for opcode 7. C is 1 when no borrow occurs.
- R7: For opcodes 2 to 7, 10 and 11, V is 1 exactly when the true signed result lies outside the 32-bit two's-complement range.
- R8: For logic opcodes, C takes shf_carry and V keeps v_in, both sampled with the operation.
- R9: N is bit 31 of the result. Z is 1 exactly when the result is zero.
- R10: Opcodes 8 to 11 (test, test-equal, compare, compare-negative) leave res_we at 0. All other accepted opcodes set res_we to 1.
- R11: res_we is never 1 while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Data-processing opcode |
| src_a | input | 32 | First operand (register value) |
| src_b | input | 32 | Second operand, already shifted |
| shf_carry | input | 1 | Carry-out of the upstream shifter |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Computed value |
| res_we | output | 1 | Result is to be written to the destination |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The properties assume that the opcode, operands and flag inputs are stable at the clock edge where in_valid is sampled high. They also assume that reset is released at a clock edge, never between edges. The bench changes every input only at the falling clock edge, so each operation is seen with settled values. The bench also keeps in_valid busy during reset, to show that the registered outputs ignore it. Both the directed corner operands and the random operands stay within the 32-bit range. The random stream mixes idle cycles into the traffic, so the valid-to-write relation is exercised in both directions.

// File: rtl/alu_pkg.sv
// Package: shared opcode and control types for the execute ALU.
// Assumes the 4-bit opcode order is fixed; the decode below depends on it.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LFN_AND  = 2'd0,
        LFN_XOR  = 2'd1,
        LFN_OR   = 2'd2,
        LFN_PASS = 2'd3
    } logic_fn_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_src_e;

    typedef struct packed {
        logic      swap;      // exchange operands before use
        logic      inv_b;     // complement the second adder/logic input
        logic      arith;     // route through adder rather than logic unit
        logic      no_write;  // flag-only operation
        cin_src_e  cin_src;   // adder carry-in source
        logic_fn_e lfn;       // logic-unit function
    } alu_ctrl_t;

    // Map an opcode onto front-end, adder and logic-unit controls.
    function automatic alu_ctrl_t alu_decode(input logic [3:0] op);
        alu_ctrl_t c;
        c = '0;
        case (alu_op_e'(op))
            OP_AND: c.lfn = LFN_AND;
            OP_EOR: c.lfn = LFN_XOR;
            OP_TST: begin c.lfn = LFN_AND; c.no_write = 1'b1; end
            OP_TEQ: begin c.lfn = LFN_XOR; c.no_write = 1'b1; end
            OP_ORR: c.lfn = LFN_OR;
            OP_MOV: c.lfn = LFN_PASS;
            OP_BIC: begin c.lfn = LFN_AND; c.inv_b = 1'b1; end
            OP_MVN: begin c.lfn = LFN_PASS; c.inv_b = 1'b1; end
            OP_ADD: c.arith = 1'b1;
            OP_CMN: begin c.arith = 1'b1; c.no_write = 1'b1; end
            OP_ADC: begin c.arith = 1'b1; c.cin_src = CIN_FLAG; end
            OP_SUB: begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin_src = CIN_ONE; end
            OP_CMP: begin
                c.arith = 1'b1; c.inv_b = 1'b1; c.cin_src = CIN_ONE; c.no_write = 1'b1;
            end
            OP_SBC: begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin_src = CIN_FLAG; end
            OP_RSB: begin
                c.arith = 1'b1; c.swap = 1'b1; c.inv_b = 1'b1; c.cin_src = CIN_ONE;
            end
            OP_RSC: begin
                c.arith = 1'b1; c.swap = 1'b1; c.inv_b = 1'b1; c.cin_src = CIN_FLAG;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_front.sv
// Module: operand swap/invert front end.
// Optionally exchanges the two operands, then optionally complements the
// operand that lands on the second input. Purely combinational.
module alu_front #(
    parameter int W = 32
) (
    input  logic         swap,
    input  logic         inv_b,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] x,
    output logic [W-1:0] y
);

    logic [W-1:0] y_raw;

    // Select operand order, then apply the complement to the second input.
    always_comb begin
        x     = swap ? opb : opa;
        y_raw = swap ? opa : opb;
        y     = inv_b ? ~y_raw : y_raw;
    end

endmodule

// File: rtl/alu_wide_add.sv
// Module: double-width adder used in its upper half only.
// The operands occupy the upper W bits; the lower half is zero except for
// its top bit, which both inputs set to the carry-in so the carry enters
// bit W with no separate carry path. Assumes W >= 2.
module alu_wide_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int AW = 2 * W;

    logic [AW-1:0] ax;
    logic [AW-1:0] ay;
    logic [AW:0]   full;
    logic [W-1:0]  lo_unused;

    // Place operands high and the carry-injection bit at the top of the low half.
    always_comb begin
        ax        = {x, cin, {(W-1){1'b0}}};
        ay        = {y, cin, {(W-1){1'b0}}};
        full      = {1'b0, ax} + {1'b0, ay};
        sum       = full[AW-1:W];
        cout      = full[AW];
        lo_unused = full[W-1:0];
        ovf       = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end

endmodule

// File: rtl/alu_logic.sv
// Module: bitwise logic unit: AND, XOR, OR or pass of the second input.
// Any complement has already been applied by the front end.
module alu_logic #(
    parameter int W = 32
) (
    input  alu_pkg::logic_fn_e fn,
    input  logic [W-1:0]       x,
    input  logic [W-1:0]       y,
    output logic [W-1:0]       out
);

    // Pick the bitwise function requested by the decode.
    always_comb begin
        case (fn)
            alu_pkg::LFN_AND:  out = x & y;
            alu_pkg::LFN_XOR:  out = x ^ y;
            alu_pkg::LFN_OR:   out = x | y;
            default:           out = y;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
// Module: condition flag generation.
// N and Z come from the selected value; C and V come from the adder for
// arithmetic and from the shifter carry / old overflow for logic.
module alu_flag_gen #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         arith,
    input  logic         add_cout,
    input  logic         add_ovf,
    input  logic         shf_c,
    input  logic         v_old,
    output logic         n,
    output logic         z,
    output logic         c,
    output logic         v
);

    // Derive the four flags from the chosen path.
    always_comb begin
        n = value[W-1];
        z = ~|value;
        c = arith ? add_cout : shf_c;
        v = arith ? add_ovf  : v_old;
    end

endmodule

// File: rtl/exu_alu.sv
// Module: execute-stage ALU top.
// Decodes the opcode, runs the front end, logic unit and wide adder in
// parallel, and registers result, write enable and flags one cycle later.
// Assumes inputs are stable at the sampling edge; reset is synchronous,
// active low, and clears the valid and write-enable outputs.
module exu_alu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         shf_carry,
    input  logic         c_in,
    input  logic         v_in,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         res_we,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);

    alu_pkg::alu_ctrl_t ctl;
    logic [W-1:0] fx, fy, lg_out, add_sum, value;
    logic         add_cin, add_cout, add_ovf;
    logic         nf, zf, cf, vf;

    // Decode the opcode and choose the adder carry-in.
    always_comb begin
        ctl = alu_pkg::alu_decode(op_sel);
        case (ctl.cin_src)
            alu_pkg::CIN_ONE:  add_cin = 1'b1;
            alu_pkg::CIN_FLAG: add_cin = c_in;
            default:           add_cin = 1'b0;
        endcase
    end

    alu_front #(.W(W)) u_front (
        .swap  (ctl.swap),
        .inv_b (ctl.inv_b),
        .opa   (src_a),
        .opb   (src_b),
        .x     (fx),
        .y     (fy)
    );

    alu_logic #(.W(W)) u_logic (
        .fn  (ctl.lfn),
        .x   (fx),
        .y   (fy),
        .out (lg_out)
    );

    alu_wide_add #(.W(W)) u_add (
        .x    (fx),
        .y    (fy),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    // Select the adder or logic-unit value.
    always_comb begin
        value = ctl.arith ? add_sum : lg_out;
    end

    alu_flag_gen #(.W(W)) u_flags (
        .value    (value),
        .arith    (ctl.arith),
        .add_cout (add_cout),
        .add_ovf  (add_ovf),
        .shf_c    (shf_carry),
        .v_old    (v_in),
        .n        (nf),
        .z        (zf),
        .c        (cf),
        .v        (vf)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_we    <= 1'b0;
            result    <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_c    <= 1'b0;
            flag_v    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            res_we    <= in_valid & ~ctl.no_write;
            if (in_valid) begin
                result <= value;
                flag_n <= nf;
                flag_z <= zf;
                flag_c <= cf;
                flag_v <= vf;
            end
        end
    end

endmodule

// File: rtl/alu_chk.sv
// Module: property checker for exu_alu, attached through bind below.
// Assumes reset is applied at a clock edge.
module alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op_sel,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic         shf_carry,
    input logic         v_in,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         res_we,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);

    logic is_logic_op;

    // Classify the incoming opcode as a logic operation.
    always_comb begin
        is_logic_op = (op_sel == 4'd0) || (op_sel == 4'd1) || (op_sel == 4'd8) ||
                      (op_sel == 4'd9) || (op_sel >= 4'd12);
    end

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> out_valid);

    // R9
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == result[W-1]));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0)));

    // R10
    flag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[3:2] == 2'b10) |=> !res_we);

    // R8
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_logic_op) |=> (flag_c == $past(shf_carry) && flag_v == $past(v_in)));

    // R3
    move_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd13) |=> (result == $past(src_b)));

    // R4
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd4) |=> (result == $past(src_a) + $past(src_b)));

endmodule

bind exu_alu alu_chk #(.W(W)) u_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .shf_carry (shf_carry),
    .v_in      (v_in),
    .out_valid (out_valid),
    .result    (result),
    .res_we    (res_we),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
);

// File: tb/exu_alu_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference with a queue of expected outputs, compared
// at every falling edge against the registered outputs of exu_alu.
module exu_alu_bench;

    typedef struct packed {
        logic        vld;
        logic        we;
        logic [3:0]  op;
        logic [31:0] res;
        logic        n, z, c, v;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        shf_carry = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic        out_valid, res_we, flag_n, flag_z, flag_c, flag_v;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    exp_t pq[$];

    always #4 clk = ~clk;

    exu_alu u_exu_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .shf_carry(shf_carry), .c_in(c_in),
        .v_in(v_in), .out_valid(out_valid), .result(result), .res_we(res_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic bit is_arith(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        if (op == 4'd4 || op == 4'd5 || op == 4'd11) return "R4";
        if (op == 4'd2 || op == 4'd6 || op == 4'd10) return "R5";
        if (op == 4'd3 || op == 4'd7) return "R6";
        return "R3";
    endfunction

    // Behavioural reference: exact integer arithmetic, flags from ranges.
    function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                   input bit sc, input bit ci, input bit vi);
        exp_t e;
        longint ua, ub, sa, sb, u, s, k;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        k  = ci ? 64'sd1 : 64'sd0;
        e = '0;
        e.vld = 1'b1; e.op = op;
        e.we = !(op >= 4'd8 && op <= 4'd11);
        u = 0; s = 0;
        case (op)
            4'd4, 4'd11: begin u = ua + ub; s = sa + sb; end
            4'd5:        begin u = ua + ub + k; s = sa + sb + k; end
            4'd2, 4'd10: begin u = ua - ub; s = sa - sb; end
            4'd6:        begin u = ua - ub - 1 + k; s = sa - sb - 1 + k; end
            4'd3:        begin u = ub - ua; s = sb - sa; end
            4'd7:        begin u = ub - ua - 1 + k; s = sb - sa - 1 + k; end
            default:     u = 0;
        endcase
        if (is_arith(op)) begin
            e.res = u[31:0];
            if (op == 4'd4 || op == 4'd5 || op == 4'd11) e.c = (u > 64'sd4294967295);
            else e.c = (u >= 0);
            e.v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            case (op)
                4'd0, 4'd8: e.res = a & b;
                4'd1, 4'd9: e.res = a ^ b;
                4'd12:      e.res = a | b;
                4'd13:      e.res = b;
                4'd14:      e.res = a & ~b;
                default:    e.res = ~b;
            endcase
            e.c = sc;
            e.v = vi;
        end
        e.n = e.res[31];
        e.z = (e.res == 32'd0);
        return e;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R2", "out_valid", {31'd0, out_valid}, {31'd0, e.vld});
        if (!e.vld) begin
            chk("R11", "res_we idle", {31'd0, res_we}, 32'd0);
        end else begin
            chk("R10", "res_we", {31'd0, res_we}, {31'd0, e.we});
            chk(res_tag(e.op), "result", result, e.res);
            chk("R9", "flag_n", {31'd0, flag_n}, {31'd0, e.n});
            chk("R9", "flag_z", {31'd0, flag_z}, {31'd0, e.z});
            chk(is_arith(e.op) ? res_tag(e.op) : "R8", "flag_c", {31'd0, flag_c}, {31'd0, e.c});
            chk(is_arith(e.op) ? "R7" : "R8", "flag_v", {31'd0, flag_v}, {31'd0, e.v});
        end
    endtask

    // One cycle: check the previous operation, then present a new one.
    task automatic drive(input bit v, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input bit sc, input bit ci, input bit vi);
        exp_t e;
        @(negedge clk);
        if (pq.size() > 0) compare(pq.pop_front());
        in_valid = v; op_sel = op; src_a = a; src_b = b;
        shf_carry = sc; c_in = ci; v_in = vi;
        e = '0;
        if (v) e = model(op, a, b, sc, ci, vi);
        pq.push_back(e);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic logic [31:0] pick(input int sel);
        case (sel)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        // R1: keep in_valid busy during reset; outputs must stay idle.
        in_valid = 1'b1; op_sel = 4'd4; src_a = 32'd5; src_b = 32'd7;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1", "res_we in reset", {31'd0, res_we}, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;

        // R4 carry and zero, R7 overflow on add
        drive(1, 4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0);
        drive(1, 4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0);
        drive(1, 4'd5, 32'hFFFF_FFFE, 32'h0000_0001, 0, 1, 0);
        drive(1, 4'd11, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        // R5 equal, borrow, signed overflow, carry forms
        drive(1, 4'd2, 32'd1234, 32'd1234, 0, 0, 0);
        drive(1, 4'd2, 32'd0, 32'd1, 0, 0, 0);
        drive(1, 4'd10, 32'h8000_0000, 32'd1, 0, 0, 0);
        drive(1, 4'd6, 32'd10, 32'd3, 0, 0, 0);
        drive(1, 4'd6, 32'd10, 32'd3, 0, 1, 0);
        // R6 reverse forms
        drive(1, 4'd3, 32'd3, 32'd10, 0, 0, 0);
        drive(1, 4'd7, 32'd10, 32'd3, 0, 0, 0);
        drive(1, 4'd7, 32'd3, 32'd3, 0, 1, 0);
        // R3, R8 logic forms with shifter carry and preserved V
        drive(1, 4'd0, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 0, 1);
        drive(1, 4'd1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 1, 0);
        drive(1, 4'd12, 32'h0000_00F0, 32'h8000_000F, 1, 0, 0);
        drive(1, 4'd13, 32'h1234_5678, 32'h0000_0000, 0, 0, 1);
        drive(1, 4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1, 1, 1);
        drive(1, 4'd15, 32'h0, 32'hFFFF_FFFF, 0, 0, 0);
        // R10 flag-only forms, then idle cycle (R11)
        drive(1, 4'd8, 32'h0000_0F00, 32'h0000_00FF, 1, 0, 0);
        drive(1, 4'd9, 32'h5555_5555, 32'h5555_5555, 0, 0, 1);
        drive(0, 4'd4, 32'd1, 32'd1, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 5) != 0, 4'($urandom), pick($urandom % 8), pick($urandom % 8),
                  1'($urandom), 1'($urandom), 1'($urandom));
        end
        drive(0, 4'd0, 32'd0, 32'd0, 0, 0, 0);
        drive(0, 4'd0, 32'd0, 32'd0, 0, 0, 0);
        finish_run();
    end

endmodule